// File: doc/BRIEF.md
# Turntable Stepper and Laser Controller

This block drives a rotating platform through a stepper-motor driver and switches a line laser. Software programs a half-period reload value into a configuration register. It then writes one action word that holds a step count, a rotation direction and the desired laser state. That single write starts both the rotation and the laser update. A status word reports whether a move is still running and whether the last action has completed. Software polls the completion flag before it takes the next camera frame, so the platform is at rest during the capture.

The step output is a square wave paced by an internal down-counting timer. Its high and low phases each last the latched half-period. The direction output is settled one full step period before the first pulse. A command with zero steps only changes the laser and completes at once.

Top module: `tstl_top`

## Requirements
- R1: After synchronous reset, step, direction and laser outputs are 0, the status word reads 0, and the configuration register reads back the `CFG_RESET` parameter.
- R2: An accepted action write sets the laser output to bit 17 of the written word and, for a nonzero step count in bits 15:0, the direction output to bit 16, visible the cycle after the write.
- R3: With effective half-period H, the first rising edge of the step output appears 2H cycles after the accepted action write, so direction leads the first step by one full period.
- R4: The step output produces exactly N rising edges for step count N, each high phase lasts H cycles, and the output is low whenever no move is running.
- R5: The status word at address 2 has busy at bit 0 and done at bit 1. Done becomes 1 exactly 2H(N+1) cycles after the write for N>0. Busy is 1 throughout the move, and busy and done are never 1 together.
- R6: A step count of zero updates only the laser, leaves direction unchanged, produces no step pulse, and shows done in the cycle after the write.
- R7: An action write (address 1) while busy is ignored: the running move, the outputs and the action readback stay unchanged.
- R8: An accepted action write with nonzero count clears done in the cycle after the write.
- R9: The half-period comes from the configuration register (address 0, bits 15:0), is latched when a move starts, so a later configuration write does not alter that move, and a value of 0 behaves as 1.
- R10: The direction output does not change while a move is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 configuration, 1 action |
| wr_data | input | 18 | Write data |
| rd_addr | input | 2 | Read address: 0 configuration, 1 action, 2 status |
| rd_data | output | 18 | Combinational read data |
| step_o | output | 1 | Step pulse to the motor driver |
| dir_o | output | 1 | Rotation direction to the motor driver |
| laser_o | output | 1 | Laser enable |

## Verification
The write is counted as cycle 0, and the bench samples on the falling edge after each rising edge. Laser, direction, busy and the cleared done flag are due at cycle 0. The first step rise is due at cycle 2H, each high phase lasts H cycles, and done is due at cycle 2H(N+1), or at cycle 0 for a zero count. The bench numbers every sample from the write and compares rise positions, phase lengths and the done cycle against these formulas over a sweep of H and N. Mid-move writes are injected at a known cycle, so their lack of effect shows up at those same due cycles.

// File: rtl/tstl_pkg.sv
package tstl_pkg;

    localparam int STEP_W    = 16;
    localparam int TMR_W     = 16;
    localparam int REG_W     = STEP_W + 2;
    localparam int ADDR_W    = 2;

    localparam logic [ADDR_W-1:0] A_CFG  = 2'd0;
    localparam logic [ADDR_W-1:0] A_ACT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LEAD,
        PH_HIGH,
        PH_LOW
    } phase_e;

    typedef struct packed {
        logic              laser;
        logic              dir;
        logic [STEP_W-1:0] steps;
    } act_cmd_t;

    function automatic act_cmd_t unpack_act(input logic [REG_W-1:0] w);
        return act_cmd_t'(w);
    endfunction

    function automatic logic [TMR_W-1:0] eff_half(input logic [TMR_W-1:0] r);
        return (r == '0) ? TMR_W'(1) : r;
    endfunction

    function automatic logic [TMR_W:0] lead_load(input logic [TMR_W-1:0] h);
        return {h, 1'b0} - (TMR_W+1)'(1);
    endfunction

    function automatic logic [TMR_W:0] phase_load(input logic [TMR_W-1:0] h);
        return {1'b0, h} - (TMR_W+1)'(1);
    endfunction

endpackage

// File: rtl/tstl_regfile.sv
module tstl_regfile
    import tstl_pkg::*;
#(
    parameter logic [TMR_W-1:0] CFG_RESET = 16'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic [TMR_W-1:0]  cfg_o,
    output act_cmd_t          cmd_o,
    output logic              start_o
);

    logic [TMR_W-1:0] cfg_q;
    logic [REG_W-1:0] act_q;
    logic             act_hit;

    assign act_hit = wr_en && (wr_addr == A_ACT);
    assign start_o = act_hit && !busy_i;
    assign cmd_o   = unpack_act(wr_data);
    assign cfg_o   = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
            act_q <= '0;
        end else begin
            if (wr_en && (wr_addr == A_CFG)) begin
                cfg_q <= wr_data[TMR_W-1:0];
            end
            if (start_o) begin
                act_q <= wr_data;
            end
        end
    end

    always_comb begin
        case (rd_addr)
            A_CFG:   rd_data = REG_W'(cfg_q);
            A_ACT:   rd_data = act_q;
            A_STAT:  rd_data = REG_W'({done_i, busy_i});
            default: rd_data = '0;
        endcase
    end

    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (act_hit && busy_i) |=> $stable(act_q)); // R7

endmodule

// File: rtl/tstl_pace_timer.sv
module tstl_pace_timer
    import tstl_pkg::*;
#(
    parameter int CNT_W = TMR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/tstl_step_seq.sv
module tstl_step_seq
    import tstl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  act_cmd_t         cmd_i,
    input  logic [TMR_W-1:0] cfg_i,
    input  logic             expire_i,
    output logic             tmr_load_o,
    output logic [TMR_W:0]   tmr_val_o,
    output logic             step_o,
    output logic             dir_o,
    output logic             laser_o,
    output logic             busy_o,
    output logic             done_o
);

    phase_e            phase_q;
    logic [TMR_W-1:0]  half_q;
    logic [STEP_W-1:0] left_q;
    logic              step_q, dir_q, laser_q, done_q;
    logic              move_start;
    logic              advance;

    assign move_start = start_i && (cmd_i.steps != '0);
    assign advance    = (phase_q != PH_IDLE) && expire_i;

    always_comb begin
        tmr_load_o = move_start || advance;
        if (move_start) begin
            tmr_val_o = lead_load(eff_half(cfg_i));
        end else begin
            tmr_val_o = phase_load(half_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            half_q  <= TMR_W'(1);
            left_q  <= '0;
            step_q  <= 1'b0;
            dir_q   <= 1'b0;
            laser_q <= 1'b0;
            done_q  <= 1'b0;
        end else if (start_i) begin
            laser_q <= cmd_i.laser;
            if (move_start) begin
                dir_q   <= cmd_i.dir;
                half_q  <= eff_half(cfg_i);
                left_q  <= cmd_i.steps;
                phase_q <= PH_LEAD;
                done_q  <= 1'b0;
            end else begin
                done_q  <= 1'b1;
            end
        end else if (advance) begin
            case (phase_q)
                PH_LEAD: begin
                    phase_q <= PH_HIGH;
                    step_q  <= 1'b1;
                end
                PH_HIGH: begin
                    phase_q <= PH_LOW;
                    step_q  <= 1'b0;
                end
                PH_LOW: begin
                    if (left_q == STEP_W'(1)) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        left_q  <= left_q - STEP_W'(1);
                        phase_q <= PH_HIGH;
                        step_q  <= 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign step_o  = step_q;
    assign dir_o   = dir_q;
    assign laser_o = laser_q;
    assign busy_o  = (phase_q != PH_IDLE);
    assign done_o  = done_q;

    AST_STEP_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !step_o); // R4
    AST_RISE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(step_o) |-> $past(busy_o)); // R3
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o)); // R5
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(dir_o)); // R10
    AST_LASER_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(laser_o)); // R7

endmodule

// File: rtl/tstl_top.sv
module tstl_top
    import tstl_pkg::*;
#(
    parameter logic [TMR_W-1:0] CFG_RESET = 16'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              step_o,
    output logic              dir_o,
    output logic              laser_o
);

    logic             busy, done, start, expire, tmr_load;
    logic [TMR_W-1:0] cfg;
    logic [TMR_W:0]   tmr_val;
    act_cmd_t         cmd;

    tstl_regfile #(.CFG_RESET(CFG_RESET)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .busy_i  (busy),
        .done_i  (done),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg_o   (cfg),
        .cmd_o   (cmd),
        .start_o (start)
    );

    tstl_pace_timer #(.CNT_W(TMR_W + 1)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire_o (expire)
    );

    tstl_step_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .cmd_i      (cmd),
        .cfg_i      (cfg),
        .expire_i   (expire),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .step_o     (step_o),
        .dir_o      (dir_o),
        .laser_o    (laser_o),
        .busy_o     (busy),
        .done_o     (done)
    );

endmodule

// File: tb/tb_tstl_top.sv
module tb_tstl_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [17:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd2;
    logic [17:0] rd_data;
    logic        step_o, dir_o, laser_o;

    int checks = 0;
    int failures = 0;
    logic cur_dir = 1'b0;

    always #5 clk = ~clk;

    tstl_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .step_o(step_o), .dir_o(dir_o), .laser_o(laser_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [17:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [17:0] act_word(input logic l, input logic d, input int n);
        return {l, d, 16'(n)};
    endfunction

    // Starts a move; sample k counts falling edges after the write edge.
    task automatic run_move(input int h, input int n, input logic d, input logic l,
                            input int inj_k, input logic [1:0] inj_a, input logic [17:0] inj_d);
        int rises = 0, first_rise = -1, done_k = -1, hi = 0, hi_bad = 0, dir_bad = 0;
        int limit = 2*h*(n+1) + 8;
        logic prev = 1'b0;
        logic exp_dir = (n > 0) ? d : cur_dir;
        rd_addr = 2'd2;
        wr(2'd1, act_word(l, d, n));
        chk("R2 laser after write", int'(laser_o), int'(l));
        chk("R2 R6 dir after write", int'(dir_o), int'(exp_dir));
        chk("R5 busy at write", int'(rd_data[0]), (n > 0) ? 1 : 0);
        chk("R8 R6 done at write", int'(rd_data[1]), (n > 0) ? 0 : 1);
        for (int k = 0; k <= limit; k++) begin
            if (k > 0) @(negedge clk);
            if (k == inj_k) begin
                wr_en = 1'b1; wr_addr = inj_a; wr_data = inj_d;
            end else if (k == inj_k + 1) begin
                wr_en = 1'b0;
            end
            if (dir_o !== exp_dir || laser_o !== l) dir_bad++;
            if (step_o && !prev) begin
                rises++;
                if (first_rise < 0) first_rise = k;
            end
            if (step_o) hi++;
            if (!step_o && prev) begin
                if (hi != h) hi_bad++;
                hi = 0;
            end
            prev = step_o;
            if (rd_data[1] && done_k < 0) begin
                done_k = k;
                break;
            end
        end
        wr_en = 1'b0;
        chk("R4 rising edge count", rises, n);
        if (n > 0) chk("R3 first rise cycle", first_rise, 2*h);
        chk("R4 high phase length errors", hi_bad, 0);
        chk("R10 R7 dir/laser held", dir_bad, 0);
        chk("R5 R6 done cycle", done_k, (n > 0) ? 2*h*(n+1) : 0);
        chk("R4 step low at done", int'(step_o), 0);
        cur_dir = exp_dir;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 step reset", int'(step_o), 0);
        chk("R1 dir reset", int'(dir_o), 0);
        chk("R1 laser reset", int'(laser_o), 0);
        rd_addr = 2'd2; #1;
        chk("R1 status reset", int'(rd_data), 0);
        rd_addr = 2'd0; #1;
        chk("R1 config reset", int'(rd_data), 4);

        // Sweep half-period and step count
        for (int h = 1; h <= 3; h++) begin
            wr(2'd0, 18'(h));
            for (int n = 0; n <= 3; n++) begin
                run_move(h, n, logic'((h + n) % 2), logic'(n % 2), -5, 2'd0, '0);
            end
        end

        // R7: action write during a move is ignored
        wr(2'd0, 18'd2);
        run_move(2, 3, 1'b1, 1'b0, 3, 2'd1, act_word(1'b1, 1'b0, 1));
        rd_addr = 2'd1; #1;
        chk("R7 action readback unchanged", int'(rd_data), int'(act_word(1'b0, 1'b1, 3)));

        // R9: config written mid-move does not change that move
        run_move(2, 2, 1'b0, 1'b1, 1, 2'd0, 18'd5);
        rd_addr = 2'd0; #1;
        chk("R9 config readback", int'(rd_data), 5);
        run_move(5, 1, 1'b1, 1'b1, -5, 2'd0, '0);

        // R9: zero half-period behaves as one
        wr(2'd0, 18'd0);
        rd_addr = 2'd0; #1;
        chk("R9 config zero readback", int'(rd_data), 0);
        run_move(1, 2, 1'b0, 1'b0, -5, 2'd0, '0);

        // R6: zero count after a move keeps direction
        run_move(1, 0, 1'b1, 1'b1, -5, 2'd0, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule